// File: doc/BRIEF.md
# Offset Calibration Sequencer

This block runs an automatic output-offset nulling cycle for an analog signal path. A calibration starts on the rising edge of a request line, which is driven either by the end of a configuration write or by an explicit software or board request. The sequencer first waits a fixed settle interval, so that the analog path can recover from a new setting. It then asserts a control that shorts the signal inputs together and runs a successive-approximation search on a trim code. On each trial step it reads a comparator that reports the sign of the residual offset. When the last bit has been decided it releases the short and holds the trim code.

Durations are counted in system clock cycles. The default settle interval is about 0.5 µs and the default null phase is about 2.5 µs at 200 MHz. A new request that arrives while a cycle is running restarts that cycle from the settle wait. While chip enable is low the sequencer is idle and the trim code is forced to mid-scale, so the trim result does not survive standby and a new calibration is needed afterwards.

Top module: `offset_cal_seq`

## Requirements
- R1: After reset, and in every cycle while chip_en_i is low, trim_o equals mid-scale (only bit TRIM_W-1 set, 32 for the default 6 bits), and busy_o and short_o are 0.
- R2: A 0-to-1 transition of cal_req_i sampled at a clock edge while chip_en_i is high starts a cycle, and busy_o is 1 after that edge. Holding cal_req_i high does not start another cycle.
- R3: A cycle begins with SETTLE_CYC cycles in which busy_o is 1 and short_o is 0.
- R4: Directly after the settle interval, short_o is 1 for exactly TRIM_W*STEP_CYC cycles.
- R5: The search is MSB first. Each step lasts STEP_CYC cycles, and the first step presents mid-scale on trim_o. In the last cycle of a step, the trial bit is kept if cmp_i is 1 (the offset is still on the same side) and cleared if cmp_i is 0. The next lower bit is set as the new trial.
- R6: busy_o falls in the same cycle as short_o. trim_o then holds the searched code, which equals the largest code for which the comparator reports 1, until the next cycle or until a disable.
- R7: A new rising edge of cal_req_i during a running cycle restarts it from the start of the settle interval. The full settle and null timing follow, and the search starts again from mid-scale.
- R8: Driving chip_en_i low aborts a running cycle at the next edge. Request edges seen while chip_en_i is low are ignored. After re-enable, trim_o stays at mid-scale until a new cycle is started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cal_req_i | input | 1 | Calibration request; the rising edge triggers a cycle |
| chip_en_i | input | 1 | Chip enable; low means standby |
| cmp_i | input | 1 | Comparator sign; 1 means the offset is still on the starting side |
| trim_o | output | TRIM_W | Offset trim code |
| short_o | output | 1 | Input-short control, high during the null phase |
| busy_o | output | 1 | High from the trigger until the last bit is decided |

## Verification
The hardest situation to reach from the ports is a request edge that lands inside the null phase, after the search has partly resolved the code. The restart must discard that partial code and rerun the full timing. The stimulus gets there by counting clock edges after a start, dropping the request for one cycle and raising it again in the middle of the bit steps, with a different comparator target. Random targets, including both end codes, drive a comparator model, and an abort by chip enable in the middle of a search is checked the same way.

// File: rtl/ocs_pkg.sv
package ocs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_NULL   = 2'd2
  } ocs_state_e;
endpackage

// File: rtl/ocs_trigger.sv
module ocs_trigger (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic req_i,
  output logic trig_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_i;
  end

  assign trig_o = req_i & ~req_q & en_i;
endmodule

// File: rtl/ocs_timer.sv
module ocs_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      last_load_q <= '0;
    end else if (load_i) begin
      cnt_q       <= load_val_i;
      last_load_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

  // count never climbs above the window it was loaded with
  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_load_q);
endmodule

// File: rtl/ocs_sar.sv
module ocs_sar #(
  parameter int unsigned TRIM_W = 6,
  localparam int unsigned IDX_W = (TRIM_W > 1) ? $clog2(TRIM_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic              step_i,
  input  logic              keep_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              last_o
);
  localparam logic [TRIM_W-1:0] MID = TRIM_W'(1) << (TRIM_W - 1);

  logic [TRIM_W-1:0] trim_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trim_q <= MID;
      idx_q  <= IDX_W'(TRIM_W - 1);
    end else if (clr_i) begin
      trim_q <= MID;
      idx_q  <= IDX_W'(TRIM_W - 1);
    end else if (start_i) begin
      trim_q <= MID;
      idx_q  <= IDX_W'(TRIM_W - 1);
    end else if (step_i) begin
      for (int b = 0; b < TRIM_W; b++) begin
        if (b == int'(idx_q) && !keep_i)       trim_q[b] <= 1'b0;
        if (b + 1 == int'(idx_q))              trim_q[b] <= 1'b1;
      end
      if (idx_q != '0) idx_q <= idx_q - 1'b1;
    end
  end

  assign trim_o = trim_q;
  assign last_o = (idx_q == '0);

  // bits below the trial position are still undecided and must be zero
  p_low_bits_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> ((trim_q & ((TRIM_W'(1) << idx_q) - 1'b1)) == '0));
endmodule

// File: rtl/offset_cal_seq.sv
module offset_cal_seq
  import ocs_pkg::*;
#(
  parameter int unsigned TRIM_W     = 6,
  parameter int unsigned SETTLE_CYC = 100,
  parameter int unsigned STEP_CYC   = 83,
  localparam int unsigned MAX_CYC   = (SETTLE_CYC > STEP_CYC) ? SETTLE_CYC : STEP_CYC,
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cal_req_i,
  input  logic              chip_en_i,
  input  logic              cmp_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              short_o,
  output logic              busy_o
);
  localparam logic [TRIM_W-1:0] MID = TRIM_W'(1) << (TRIM_W - 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] STEP_LD   = CNT_W'(STEP_CYC - 1);

  ocs_state_e       state_q, state_d;
  logic             trig, expired, last;
  logic             tmr_load, sar_start, sar_step;
  logic [CNT_W-1:0] tmr_val;

  ocs_trigger u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (chip_en_i),
    .req_i  (cal_req_i),
    .trig_o (trig)
  );

  ocs_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (expired)
  );

  ocs_sar #(.TRIM_W(TRIM_W)) u_sar (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (~chip_en_i),
    .start_i (sar_start),
    .step_i  (sar_step),
    .keep_i  (cmp_i),
    .trim_o  (trim_o),
    .last_o  (last)
  );

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = STEP_LD;
    sar_start = 1'b0;
    sar_step  = 1'b0;
    if (!chip_en_i) begin
      state_d = ST_IDLE;
    end else if (trig) begin
      // any request edge, even mid-cycle, restarts from the settle wait
      state_d  = ST_SETTLE;
      tmr_load = 1'b1;
      tmr_val  = SETTLE_LD;
    end else begin
      unique case (state_q)
        ST_SETTLE: if (expired) begin
          state_d   = ST_NULL;
          tmr_load  = 1'b1;
          sar_start = 1'b1;
        end
        ST_NULL: if (expired) begin
          sar_step = 1'b1;
          if (last) state_d  = ST_IDLE;
          else      tmr_load = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign short_o = (state_q == ST_NULL);

  p_short_in_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_o |-> busy_o);

  p_trig_starts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> (busy_o && !short_o));

  p_disable_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chip_en_i |=> (!busy_o && trim_o == MID));

  p_trim_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o) && chip_en_i && $past(chip_en_i)) |-> $stable(trim_o));
endmodule

// File: tb/offset_cal_seq_bench.sv
module offset_cal_seq_bench;
  localparam int W = 6;
  localparam int S = 10;
  localparam int P = 4;
  localparam int N = S + W * P;
  localparam int MID = 1 << (W - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic en = 1'b1;
  logic cmp;
  logic [W-1:0] trim;
  logic short_s, busy;
  int target = 0;
  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // comparator model: offset still on starting side while code has not passed target
  assign cmp = (int'(trim) <= target);

  offset_cal_seq #(.TRIM_W(W), .SETTLE_CYC(S), .STEP_CYC(P)) u_offset_cal_seq (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cal_req_i (req),
    .chip_en_i (en),
    .cmp_i     (cmp),
    .trim_o    (trim),
    .short_o   (short_s),
    .busy_o    (busy)
  );

  task automatic check(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // req was raised at the previous negedge; follow the full cycle
  task automatic watch(int tgt);
    for (int i = 0; i <= N; i++) begin
      @(negedge clk);
      check("R2/R3/R6 busy", int'(busy), (i < N) ? 1 : 0);
      check("R3/R4 short", int'(short_s), (i >= S && i < N) ? 1 : 0);
      if (i == S) check("R5 first trial mid", int'(trim), MID);
      if (i == N) check("R5/R6 final code", int'(trim), tgt);
    end
    @(negedge clk);
    check("R2 held level no restart", int'(busy), 0);
    check("R6 code held", int'(trim), tgt);
  endtask

  task automatic run_cal(int tgt);
    target = tgt;
    req = 1'b1;
    watch(tgt);
    req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    process::self().srandom(32'h5eed_0c5);
    repeat (3) @(negedge clk);
    check("R1 reset trim", int'(trim), MID);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset short", int'(short_s), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_cal(0);
    run_cal((1 << W) - 1);
    run_cal(MID);
    run_cal(MID - 1);
    for (int k = 0; k < 8; k++) run_cal(int'($urandom_range((1 << W) - 1)));

    // R7: restart in the middle of the null phase
    target = 45;
    req = 1'b1;
    repeat (S + 5) @(negedge clk);
    check("R7 in null before restart", int'(short_s), 1);
    req = 1'b0;
    @(negedge clk);
    req = 1'b1;
    target = 19;
    watch(19);
    req = 1'b0;
    @(negedge clk);

    // R8: abort by disable, ignored requests, lost trim
    target = 11;
    req = 1'b1;
    repeat (S + 6) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check("R8 abort busy", int'(busy), 0);
    check("R8 abort short", int'(short_s), 0);
    check("R8 abort trim mid", int'(trim), MID);
    req = 1'b0;
    @(negedge clk);
    req = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 request ignored while off", int'(busy), 0);
    en = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 no start on re-enable", int'(busy), 0);
    check("R8 trim lost", int'(trim), MID);
    req = 1'b0;
    @(negedge clk);
    run_cal(11);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !finished) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end
endmodule